// File: doc/BRIEF.md
# PAUSE Frame Request Generator

This block sits next to a MAC receive buffer. It watches how full the buffer is and decides when the local transmitter should send a PAUSE frame. When the fill level climbs to the high water mark, the block asks for an XOFF frame. That frame carries a programmable pause time. When the buffer drains to the low water mark, the block asks for an XON frame, which is a PAUSE frame whose pause time is zero. Between the two marks nothing changes, so the block has hysteresis and does not toggle around a single threshold.

The pause the block advertises could run out while the buffer is still congested. To prevent that, the block keeps its own copy of the advertised time. It counts that copy down in 512-bit-time slots and asks for a fresh XOFF once the remainder falls to a refresh threshold. Only one request is outstanding at a time. The frame builder acknowledges the request once the frame has gone out. A newer decision replaces a request that has not yet been acknowledged. Transmit flow control has an enable of its own, independent of how received PAUSE frames are handled.

Top module: `pause_req_gen`

## Requirements
- R1: After reset, `req_valid` is 0 and the block is in the unpaused state.
- R2: While enabled and unpaused, a fill level equal to or above `high_mark` raises `req_valid` on the next clock. `req_pause` then equals the `timer_value` sampled on that edge (an XOFF), and the block enters the paused state.
- R3: While enabled, an active request keeps `req_valid` high until a clock edge on which `req_ack` is 1. It is dropped on that edge unless a new request is raised on the same edge.
- R4: While paused, a fill level equal to or below `low_mark` raises a request with `req_pause` = 0 (an XON) on the next clock and returns the block to the unpaused state. A fill level above `low_mark` with no refresh due raises no new request.
- R5: If an XOFF is still unacknowledged when the fill level falls to `low_mark` or below, the XOFF is replaced by an XON on the next clock, without `req_valid` dropping.
- R6: An acknowledged XOFF loads a countdown with its pause value. Each `slot_tick` cycle lowers the countdown by one, stopping at zero. Once the count is at or below `refresh_thresh` and the fill is above `low_mark`, one new XOFF with the current `timer_value` is requested on the following clock.
- R7: While `tx_fc_en` is 0, `req_valid` is 0 from the next clock. Any pending request is withdrawn, the countdown is stopped, and the block returns to the unpaused state.
- R8: After an XON, no refresh XOFF is raised, whatever the slot ticks do, until the fill level again reaches `high_mark`.
- R9: While unpaused, a fill level below `high_mark` raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_fc_en | input | 1 | Enable for transmit flow control |
| fill_level | input | LVL_W (13) | Current receive buffer occupancy |
| high_mark | input | LVL_W (13) | Occupancy at which XOFF is requested |
| low_mark | input | LVL_W (13) | Occupancy at which XON is requested |
| timer_value | input | TMR_W (16) | Pause time placed in each XOFF, in slot units |
| refresh_thresh | input | TMR_W (16) | Remaining-time level that triggers a repeat XOFF |
| slot_tick | input | 1 | One-cycle pulse every 512 bit times |
| req_ack | input | 1 | The requested PAUSE frame has been sent |
| req_valid | output | 1 | A PAUSE frame send request is pending |
| req_pause | output | TMR_W (16) | Pause value for the pending frame (0 means XON) |

## Verification
A wrong paused/unpaused state shows up at the ports within one clock of the next threshold crossing. Examples are a missing XON when the buffer drains, a duplicate XOFF between the marks, or a missing XOFF after re-enable. Countdown faults appear as a refresh XOFF arriving one or more slot ticks early or late relative to the acknowledge. A lost or wrongly replaced pending request is visible on the clock after the event, either as `req_valid` dropping without an acknowledge or as `req_pause` keeping a stale value.

// File: rtl/pause_pkg.sv
package pause_pkg;

   typedef enum logic {
      FC_IDLE   = 1'b0,
      FC_PAUSED = 1'b1
   } fc_state_e;

   typedef enum logic [1:0] {
      REQ_NONE = 2'd0,
      REQ_XOFF = 2'd1,
      REQ_XON  = 2'd2
   } req_kind_e;

endpackage

// File: rtl/pause_level_cmp.sv
module pause_level_cmp #(
   parameter int LVL_W = 13
) (
   input  logic [LVL_W-1:0] fill_level,
   input  logic [LVL_W-1:0] high_mark,
   input  logic [LVL_W-1:0] low_mark,
   output logic             above_high,
   output logic             at_low
);

   generate
      if (LVL_W < 1 || LVL_W > 32) begin : g_bad_width
         $error("pause_level_cmp: LVL_W out of range");
      end
   endgenerate

   // inclusive compares on both marks give the hysteresis band
   always_comb begin
      above_high = (fill_level >= high_mark);
      at_low     = (fill_level <= low_mark);
   end

endmodule

// File: rtl/pause_refresh_timer.sv
module pause_refresh_timer #(
   parameter int TMR_W      = 16,
   parameter bit REFRESH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [TMR_W-1:0] load_value,
   input  logic             consume,
   input  logic             tick,
   input  logic [TMR_W-1:0] thresh,
   output logic             refresh_due
);

   localparam logic [TMR_W-1:0] ONE = {{(TMR_W-1){1'b0}}, 1'b1};

   generate
      if (TMR_W < 2 || TMR_W > 32) begin : g_bad_width
         $error("pause_refresh_timer: TMR_W out of range");
      end

      if (REFRESH_EN) begin : g_counter
         logic [TMR_W-1:0] count_q;
         logic             armed_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               count_q <= '0;
               armed_q <= 1'b0;
            end else if (clear) begin
               armed_q <= 1'b0;
            end else if (load) begin
               count_q <= load_value;
               armed_q <= 1'b1;
            end else if (consume) begin
               armed_q <= 1'b0;
            end else if (armed_q && tick && count_q != '0) begin
               count_q <= count_q - ONE;
            end
         end

         assign refresh_due = armed_q && (count_q <= thresh);

         // R6: one slot tick removes exactly one unit of remaining pause
         p_tick_dec_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && tick && !clear && !load && !consume && count_q != '0)
            |=> (count_q == $past(count_q) - ONE));

         // R7: a clear always disarms the countdown
         p_clear_disarms_r7 : assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> !refresh_due);
      end else begin : g_no_counter
         assign refresh_due = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
   import pause_pkg::*;
#(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             above_high,
   input  logic             at_low,
   input  logic             refresh_due,
   input  logic [TMR_W-1:0] timer_value,
   input  logic             req_ack,
   output logic             req_valid,
   output logic [TMR_W-1:0] req_pause,
   output logic [TMR_W-1:0] acked_pause,
   output logic             load_timer,
   output logic             clear_timer,
   output logic             consume_refresh
);

   fc_state_e        state_q, state_d;
   req_kind_e        pend_q,  pend_d;
   logic [TMR_W-1:0] pause_q, pause_d;

   always_comb begin
      state_d         = state_q;
      pend_d          = pend_q;
      pause_d         = pause_q;
      load_timer      = 1'b0;
      clear_timer     = 1'b0;
      consume_refresh = 1'b0;
      if (!enable) begin
         state_d     = FC_IDLE;
         pend_d      = REQ_NONE;
         pause_d     = '0;
         clear_timer = 1'b1;
      end else begin
         if (req_ack && pend_q != REQ_NONE) begin
            pend_d = REQ_NONE;
            if (pend_q == REQ_XOFF) load_timer = 1'b1;
         end
         case (state_q)
            FC_IDLE: begin
               if (above_high) begin
                  state_d = FC_PAUSED;
                  pend_d  = REQ_XOFF;
                  pause_d = timer_value;
               end
            end
            FC_PAUSED: begin
               if (at_low) begin
                  state_d     = FC_IDLE;
                  pend_d      = REQ_XON;
                  pause_d     = '0;
                  clear_timer = 1'b1;
               end else if (refresh_due && pend_q == REQ_NONE) begin
                  pend_d          = REQ_XOFF;
                  pause_d         = timer_value;
                  consume_refresh = 1'b1;
               end
            end
            default: state_d = FC_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FC_IDLE;
         pend_q  <= REQ_NONE;
         pause_q <= '0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         pause_q <= pause_d;
      end
   end

   assign req_valid   = (pend_q != REQ_NONE);
   assign req_pause   = pause_q;
   assign acked_pause = pause_q;

   // R2: crossing the high mark while unpaused yields an XOFF next cycle
   p_xoff_rise_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && state_q == FC_IDLE && above_high)
      |=> (req_valid && req_pause == $past(timer_value) && state_q == FC_PAUSED));

   // R3: an unacknowledged request survives while enabled
   p_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && req_valid && !req_ack) |=> req_valid);

   // R4: draining to the low mark while paused yields an XON
   p_xon_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && state_q == FC_PAUSED && at_low)
      |=> (req_valid && req_pause == '0 && state_q == FC_IDLE));

   // R4: between the marks with nothing due, no new request appears
   p_band_quiet_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && state_q == FC_PAUSED && !at_low && !refresh_due && !req_valid)
      |=> !req_valid);

   // R7: disabling withdraws everything
   p_disable_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!req_valid && state_q == FC_IDLE));

   // R1: state after reset is clean
   p_reset_r1 : assert property (@(posedge clk)
      $rose(rst_n) |-> (!req_valid && state_q == FC_IDLE));

endmodule

// File: rtl/pause_req_gen.sv
module pause_req_gen #(
   parameter int LVL_W      = 13,
   parameter int TMR_W      = 16,
   parameter bit REFRESH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_fc_en,
   input  logic [LVL_W-1:0] fill_level,
   input  logic [LVL_W-1:0] high_mark,
   input  logic [LVL_W-1:0] low_mark,
   input  logic [TMR_W-1:0] timer_value,
   input  logic [TMR_W-1:0] refresh_thresh,
   input  logic             slot_tick,
   input  logic             req_ack,
   output logic             req_valid,
   output logic [TMR_W-1:0] req_pause
);

   logic             above_high;
   logic             at_low;
   logic             refresh_due;
   logic             load_timer;
   logic             clear_timer;
   logic             consume_refresh;
   logic [TMR_W-1:0] acked_pause;

   pause_level_cmp #(
      .LVL_W(LVL_W)
   ) u_cmp (
      .fill_level (fill_level),
      .high_mark  (high_mark),
      .low_mark   (low_mark),
      .above_high (above_high),
      .at_low     (at_low)
   );

   pause_refresh_timer #(
      .TMR_W      (TMR_W),
      .REFRESH_EN (REFRESH_EN)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear_timer),
      .load        (load_timer),
      .load_value  (acked_pause),
      .consume     (consume_refresh),
      .tick        (slot_tick),
      .thresh      (refresh_thresh),
      .refresh_due (refresh_due)
   );

   pause_req_ctrl #(
      .TMR_W(TMR_W)
   ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .enable          (tx_fc_en),
      .above_high      (above_high),
      .at_low          (at_low),
      .refresh_due     (refresh_due),
      .timer_value     (timer_value),
      .req_ack         (req_ack),
      .req_valid       (req_valid),
      .req_pause       (req_pause),
      .acked_pause     (acked_pause),
      .load_timer      (load_timer),
      .clear_timer     (clear_timer),
      .consume_refresh (consume_refresh)
   );

endmodule

// File: tb/pause_req_gen_bench.sv
module pause_req_gen_bench;

   localparam int LVL_W = 13;
   localparam int TMR_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tx_fc_en = 1'b0;
   logic [LVL_W-1:0] fill_level = '0;
   logic [LVL_W-1:0] high_mark = 13'd100;
   logic [LVL_W-1:0] low_mark = 13'd40;
   logic [TMR_W-1:0] timer_value = 16'd10;
   logic [TMR_W-1:0] refresh_thresh = 16'd4;
   logic             slot_tick = 1'b0;
   logic             req_ack = 1'b0;
   logic             req_valid;
   logic [TMR_W-1:0] req_pause;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pause_req_gen #(.LVL_W(LVL_W), .TMR_W(TMR_W)) u_pause_req_gen (
      .clk(clk), .rst_n(rst_n), .tx_fc_en(tx_fc_en), .fill_level(fill_level),
      .high_mark(high_mark), .low_mark(low_mark), .timer_value(timer_value),
      .refresh_thresh(refresh_thresh), .slot_tick(slot_tick), .req_ack(req_ack),
      .req_valid(req_valid), .req_pause(req_pause)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_ack = 1'b0; slot_tick = 1'b0;
      fill_level = '0; tx_fc_en = 1'b1; timer_value = 16'd10;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic ack();
      req_ack = 1'b1;
      cyc(1);
      req_ack = 1'b0;
   endtask

   task automatic tick();
      slot_tick = 1'b1;
      cyc(1);
      slot_tick = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 valid after reset", req_valid, 0);
      // R1: idle means a high crossing produces an XOFF
      fill_level = 13'd150;
      cyc(1);
      chk("R1 idle state gives XOFF", req_valid, 1);
   endtask

   task automatic t_threshold();
      do_reset();
      fill_level = 13'd99;
      cyc(3);
      chk("R9 below high no request", req_valid, 0);
      fill_level = 13'd100;
      cyc(1);
      chk("R2 XOFF at high mark", req_valid, 1);
      chk("R2 XOFF pause value", req_pause, 10);
   endtask

   task automatic t_hold();
      do_reset();
      fill_level = 13'd120;
      cyc(1);
      timer_value = 16'd77;
      cyc(4);
      chk("R3 held without ack", req_valid, 1);
      chk("R3 value latched", req_pause, 10);
      ack();
      chk("R3 dropped on ack", req_valid, 0);
   endtask

   task automatic t_xon();
      do_reset();
      fill_level = 13'd110;
      cyc(1);
      ack();
      fill_level = 13'd60;
      cyc(3);
      chk("R4 quiet inside band", req_valid, 0);
      fill_level = 13'd40;
      cyc(1);
      chk("R4 XON at low mark", req_valid, 1);
      chk("R4 XON pause zero", req_pause, 0);
      ack();
      chk("R4 XON acked", req_valid, 0);
      fill_level = 13'd60;
      for (int i = 0; i < 15; i++) tick();
      cyc(2);
      chk("R8 no refresh after XON", req_valid, 0);
      fill_level = 13'd100;
      cyc(1);
      chk("R8 new XOFF after re-cross", req_valid, 1);
   endtask

   task automatic t_replace();
      do_reset();
      fill_level = 13'd130;
      cyc(1);
      chk("R5 XOFF pending", req_pause, 10);
      fill_level = 13'd20;
      cyc(1);
      chk("R5 still valid", req_valid, 1);
      chk("R5 replaced by XON", req_pause, 0);
      ack();
      chk("R5 XON acked", req_valid, 0);
   endtask

   task automatic t_refresh();
      do_reset();
      fill_level = 13'd120;
      cyc(1);
      ack();
      fill_level = 13'd70;
      for (int i = 0; i < 5; i++) tick();
      chk("R6 no refresh above thresh", req_valid, 0);
      timer_value = 16'd33;
      tick();
      chk("R6 not yet after reaching thresh", req_valid, 0);
      cyc(1);
      chk("R6 refresh XOFF", req_valid, 1);
      chk("R6 refresh value", req_pause, 33);
      ack();
      for (int i = 0; i < 28; i++) tick();
      cyc(1);
      chk("R6 second countdown not done", req_valid, 0);
      tick();
      cyc(1);
      chk("R6 second refresh", req_valid, 1);
   endtask

   task automatic t_disable();
      do_reset();
      fill_level = 13'd140;
      cyc(1);
      tx_fc_en = 1'b0;
      cyc(1);
      chk("R7 withdrawn when disabled", req_valid, 0);
      cyc(3);
      chk("R7 stays quiet disabled", req_valid, 0);
      tx_fc_en = 1'b1;
      cyc(1);
      chk("R7 back idle, XOFF again", req_valid, 1);
      chk("R7 XOFF value", req_pause, 10);
   endtask

   initial begin
      t_reset();
      t_threshold();
      t_hold();
      t_xon();
      t_replace();
      t_refresh();
      t_disable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule